// File: doc/BRIEF.md
# Switch Fault Detector Based on Mismatch Duration

This block watches the poles of a three-leg voltage-source converter and flags a leg whose output no longer follows its switching command. For each leg it takes a signed sample of the voltage from the pole to the DC-link midpoint, the DC bus voltage and the command bit of that leg's upper switch. From these it forms the pole voltage the command should give and the error against the measured value.

A short error spike is normal on every commutation, so the block does not judge how large the error is. It judges how long it lasts. A comparator with two programmable thresholds turns the error magnitude into a mismatch flag. A counter measures each unbroken run of mismatch in sample strobes and restarts from zero when the run ends. A leg is declared faulty when one run reaches a programmable length. That length should be chosen several times longer than a switching transient. The fault flag of each leg stays set until reset, ready for the reconfiguration logic that isolates the leg.

Top module: `swfd_top`

## Requirements
- R1: After a synchronous reset every fault flag is 0, every comparator is in the matched state and every run counter is 0.
- R2: The expected pole voltage is +floor(Vbus/2) when the leg's command bit is 1 and -floor(Vbus/2) when it is 0. The error is the measured value minus the expected value. Its magnitude is exact over the full signed measured range and the full unsigned bus range, reaching 2^VW-1 at worst.
- R3: On a strobe, a matched comparator becomes mismatched when the error magnitude is strictly greater than the rising threshold. A mismatched comparator returns to matched when the magnitude is less than or equal to the falling threshold, which is meant to be no larger than the rising one.
- R4: On each strobe, the run counter of a leg whose updated comparator state is mismatched increments and saturates at 2^CW-1. It is cleared to 0 on a strobe whose updated state is matched.
- R5: A leg's fault flag rises at the clock edge of the strobe on which its updated run count reaches the limit input. A limit of 0 behaves like 1. A run shorter than the limit leaves the flag at 0.
- R6: Once set, a fault flag stays 1 whatever the later inputs are, until reset.
- R7: Clock edges without the strobe change no comparator, counter or fault state, whatever the sample inputs do.
- R8: The legs are independent. The bus sample, the thresholds and the limit are shared, and a mismatch on one leg never touches another leg's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; all state advances only on cycles where it is high |
| pole_v | input | NPH x VW | Signed measured pole-to-midpoint voltage, one lane per leg |
| bus_v | input | VW | Unsigned DC bus voltage sample |
| hi_cmd | input | NPH | Upper-switch command per leg (1 = on) |
| thr_rise | input | VW+1 | Error magnitude above which the comparator enters mismatch |
| thr_fall | input | VW+1 | Error magnitude at or below which the comparator leaves mismatch |
| run_limit | input | CW | Mismatch run length, in strobes, that declares a fault |
| leg_fault | output | NPH | Latched fault flag per leg |

## Verification
The embedded properties check the cycle-level rules on every clock: the comparator enters and leaves mismatch on the right threshold comparisons, nothing moves without a strobe, the run counter clears on a match and never wraps, a fault flag only rises on a strobe whose run has reached the limit, and a set flag never drops. The exact error arithmetic is visible only through the scenarios. Sweeping measured value, bus value and command while placing the thresholds one below and exactly at the computed magnitude shows it, and that includes the full-scale extremes and odd bus values. The scenarios also cover the run lengths that just miss or just reach the limit, the counter restarting after a dip below the falling threshold, and the isolation between legs.

// File: rtl/swfd_pkg.sv
package swfd_pkg;

    localparam int SWFD_VW  = 12;
    localparam int SWFD_CW  = 10;
    localparam int SWFD_NPH = 3;

    typedef enum logic {
        CMP_MATCH    = 1'b0,
        CMP_MISMATCH = 1'b1
    } cmp_state_e;

    // One step of the two-threshold comparator.
    function automatic cmp_state_e hyst_step(cmp_state_e cur, logic above_rise, logic within_fall);
        case (cur)
            CMP_MATCH: return above_rise  ? CMP_MISMATCH : CMP_MATCH;
            default:   return within_fall ? CMP_MATCH    : CMP_MISMATCH;
        endcase
    endfunction

endpackage

// File: rtl/swfd_err.sv
module swfd_err #(
    parameter int VW = swfd_pkg::SWFD_VW
) (
    input  logic signed [VW-1:0] pole_v,
    input  logic        [VW-1:0] bus_v,
    input  logic                 hi_cmd,
    output logic        [VW:0]   err_mag
);
    localparam int EW = VW + 1;

    logic        [VW-1:0] bus_half;
    logic signed [EW-1:0] half_s;
    logic signed [EW-1:0] expect_s;
    logic signed [EW-1:0] pole_s;
    logic signed [EW-1:0] diff_s;

    always_comb begin
        bus_half = bus_v >> 1;
        half_s   = signed'({1'b0, bus_half});
        expect_s = hi_cmd ? half_s : -half_s;
        pole_s   = {pole_v[VW-1], pole_v};
        diff_s   = pole_s - expect_s;
        err_mag  = diff_s[EW-1] ? unsigned'(-diff_s) : unsigned'(diff_s);
    end

endmodule

// File: rtl/swfd_hyst.sv
module swfd_hyst #(
    parameter int MW = swfd_pkg::SWFD_VW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_stb,
    input  logic [MW-1:0] err_mag,
    input  logic [MW-1:0] thr_rise,
    input  logic [MW-1:0] thr_fall,
    output logic          mis_next,
    output logic          mis_q
);
    import swfd_pkg::*;

    cmp_state_e st_q, st_step;

    always_comb begin
        st_step  = hyst_step(st_q, err_mag > thr_rise, err_mag <= thr_fall);
        mis_next = smp_stb ? (st_step == CMP_MISMATCH) : (st_q == CMP_MISMATCH);
        mis_q    = (st_q == CMP_MISMATCH);
    end

    always_ff @(posedge clk) begin
        if (rst)          st_q <= CMP_MATCH;
        else if (smp_stb) st_q <= st_step;
    end

    p_enter_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !mis_q && err_mag > thr_rise) |=> mis_q);
    p_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mis_q && err_mag <= thr_fall) |=> !mis_q);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(mis_q));

endmodule

// File: rtl/swfd_run.sv
module swfd_run #(
    parameter int CW = swfd_pkg::SWFD_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_stb,
    input  logic          run_in,
    output logic [CW-1:0] cnt_next,
    output logic [CW-1:0] cnt_q
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    always_comb begin
        if (!smp_stb)           cnt_next = cnt_q;
        else if (!run_in)       cnt_next = '0;
        else if (cnt_q == CNT_MAX) cnt_next = CNT_MAX;
        else                    cnt_next = cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && run_in && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !run_in) |=> (cnt_q == '0));
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(cnt_q));

endmodule

// File: rtl/swfd_phase.sv
module swfd_phase #(
    parameter int VW = swfd_pkg::SWFD_VW,
    parameter int CW = swfd_pkg::SWFD_CW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [VW-1:0] pole_v,
    input  logic        [VW-1:0] bus_v,
    input  logic                 hi_cmd,
    input  logic        [VW:0]   thr_rise,
    input  logic        [VW:0]   thr_fall,
    input  logic        [CW-1:0] run_limit,
    output logic                 leg_fault
);
    logic [VW:0]   err_mag;
    logic          mis_next, mis_q;
    logic [CW-1:0] cnt_next, cnt_q;
    logic          fault_q;

    swfd_err #(.VW(VW)) u_err (
        .pole_v (pole_v),
        .bus_v  (bus_v),
        .hi_cmd (hi_cmd),
        .err_mag(err_mag)
    );

    swfd_hyst #(.MW(VW + 1)) u_hyst (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .err_mag (err_mag),
        .thr_rise(thr_rise),
        .thr_fall(thr_fall),
        .mis_next(mis_next),
        .mis_q   (mis_q)
    );

    swfd_run #(.CW(CW)) u_run (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .run_in  (mis_next),
        .cnt_next(cnt_next),
        .cnt_q   (cnt_q)
    );

    // Duration comparator; a limit of 0 acts as 1 because a live run is at least 1.
    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= 1'b0;
        else if (smp_stb && mis_next && (cnt_next >= run_limit))
            fault_q <= 1'b1;
    end

    assign leg_fault = fault_q;

    p_latch_r6: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q);
    p_rise_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (!fault_q && !smp_stb) |=> !fault_q);
    p_short_run_r5: assert property (@(posedge clk) disable iff (rst)
        (!fault_q && (cnt_next < run_limit)) |=> !fault_q);
    p_run_needs_mis_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> mis_q);

endmodule

// File: rtl/swfd_top.sv
module swfd_top #(
    parameter int VW  = swfd_pkg::SWFD_VW,
    parameter int CW  = swfd_pkg::SWFD_CW,
    parameter int NPH = swfd_pkg::SWFD_NPH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          smp_stb,
    input  logic [NPH-1:0][VW-1:0]        pole_v,
    input  logic [VW-1:0]                 bus_v,
    input  logic [NPH-1:0]                hi_cmd,
    input  logic [VW:0]                   thr_rise,
    input  logic [VW:0]                   thr_fall,
    input  logic [CW-1:0]                 run_limit,
    output logic [NPH-1:0]                leg_fault
);
    for (genvar g = 0; g < NPH; g++) begin : g_leg
        swfd_phase #(.VW(VW), .CW(CW)) u_leg (
            .clk      (clk),
            .rst      (rst),
            .smp_stb  (smp_stb),
            .pole_v   (signed'(pole_v[g])),
            .bus_v    (bus_v),
            .hi_cmd   (hi_cmd[g]),
            .thr_rise (thr_rise),
            .thr_fall (thr_fall),
            .run_limit(run_limit),
            .leg_fault(leg_fault[g])
        );
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (leg_fault == '0));

endmodule

// File: tb/swfd_top_bench.sv
`timescale 1ns/1ps
module swfd_top_bench;
    localparam int VW  = 12;
    localparam int CW  = 10;
    localparam int NPH = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst = 1'b1;
    logic                   stb = 1'b0;
    logic [NPH-1:0][VW-1:0] meas;
    logic [VW-1:0]          bus;
    logic [NPH-1:0]         cmd;
    logic [VW:0]            thr_on, thr_off;
    logic [CW-1:0]          lim;
    logic [NPH-1:0]         fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    swfd_top #(.VW(VW), .CW(CW), .NPH(NPH)) u_swfd_top (
        .clk(clk), .rst(rst), .smp_stb(stb), .pole_v(meas), .bus_v(bus),
        .hi_cmd(cmd), .thr_rise(thr_on), .thr_fall(thr_off),
        .run_limit(lim), .leg_fault(fault)
    );

    task automatic chk(string req, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic int expv(int bv, bit c);
        return c ? (bv / 2) : -(bv / 2);
    endfunction

    task automatic do_reset();
        @(negedge clk) rst = 1'b1; stb = 1'b0;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic quiet_all();
        for (int p = 0; p < NPH; p++) meas[p] = VW'(expv(int'(bus), cmd[p]));
    endtask

    task automatic pulse();
        @(negedge clk) stb = 1'b1;
        @(negedge clk) stb = 1'b0;
    endtask

    task automatic run_err(int p, int e);
        quiet_all();
        meas[p] = VW'(expv(int'(bus), cmd[p]) + e);
        pulse();
    endtask

    // R2: one strobe, limit 1, thresholds just below and exactly at |error|
    task automatic mag_case(int p, int mv, int bv, bit c);
        int e, a;
        e = mv - expv(bv, c);
        a = (e < 0) ? -e : e;
        for (int t = 0; t < 2; t++) begin
            if (t == 0 && a == 0) continue;
            do_reset();
            bus = VW'(bv); cmd = {NPH{c}}; lim = '0 + 1;
            thr_on  = (VW+1)'(t == 0 ? a - 1 : a);
            thr_off = thr_on;
            quiet_all();
            meas[p] = VW'(mv);
            pulse();
            chk(t == 0 ? "R2 above-threshold R8" : "R2 at-threshold",
                int'(fault), t == 0 ? (1 << p) : 0);
        end
    endtask

    initial begin
        meas = '0; bus = '0; cmd = '0; thr_on = '0; thr_off = '0; lim = '0;
        do_reset();
        chk("R1 reset", int'(fault), 0);

        // R2 sweep and extremes
        for (int mi = 0; mi <= 20; mi++)
            for (int bi = 0; bi < 20; bi++)
                for (int c = 0; c < 2; c++)
                    mag_case((mi + bi) % NPH, -2048 + mi * 204, bi * 215, c[0]);
        mag_case(0, -2048, 4095, 1'b1);
        mag_case(1,  2047, 4095, 1'b0);
        mag_case(2,     0,    1, 1'b1);
        mag_case(0,     1,    3, 1'b0);

        // R3 hysteresis
        do_reset();
        bus = 12'd2000; cmd = '1; thr_on = 13'd10; thr_off = 13'd3; lim = 10'd3;
        run_err(0, 11); run_err(0, 5); run_err(0, -4);
        chk("R3 hold band keeps counting", int'(fault), 1);
        do_reset();
        run_err(0, 8); run_err(0, -8); run_err(0, 10);
        chk("R3 below rising threshold", int'(fault), 0);
        do_reset();
        run_err(0, 11); run_err(0, 3); run_err(0, 11); run_err(0, 11);
        chk("R4 falling threshold clears run", int'(fault), 0);
        run_err(0, 11);
        chk("R4 run reaches limit", int'(fault), 1);

        // R5 limit boundaries
        for (int lv = 1; lv <= 6; lv++) begin
            do_reset();
            lim = CW'(lv);
            repeat (lv - 1) run_err(1, 50);
            run_err(1, 0);
            chk("R5 short run then match", int'(fault), 0);
            repeat (lv - 1) run_err(1, 50);
            chk("R5 one below limit", int'(fault), 0);
            run_err(1, 50);
            chk("R5 exact limit R8", int'(fault), 2);
        end
        do_reset();
        lim = '0;
        run_err(2, -50);
        chk("R5 zero limit", int'(fault), 4);

        // R4 saturating count up to the largest limit
        do_reset();
        lim = '1;
        repeat (1022) run_err(2, -50);
        chk("R4 count below max", int'(fault), 0);
        run_err(2, -50);
        chk("R4 count at max", int'(fault), 4);
        repeat (50) run_err(2, -50);
        chk("R4 saturated", int'(fault), 4);

        // R6 latch
        run_err(2, 0); run_err(2, 0); run_err(2, 0);
        lim = '1; thr_on = '1; thr_off = '1;
        @(negedge clk);
        chk("R6 latched", int'(fault), 4);
        do_reset();
        chk("R1 reset clears latch", int'(fault), 0);

        // R7 no strobe
        thr_on = 13'd10; thr_off = 13'd3; lim = 10'd1;
        quiet_all(); meas[0] = VW'(expv(int'(bus), 1'b1) + 500);
        repeat (20) @(negedge clk);
        chk("R7 no strobe no fault", int'(fault), 0);
        lim = 10'd2;
        run_err(0, 500);
        chk("R7 first strobe", int'(fault), 0);
        quiet_all();
        repeat (10) @(negedge clk);
        run_err(0, 500);
        chk("R7 idle keeps run", int'(fault), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule